// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns a signed product of twice that width. It works serially. Each step examines two new multiplier bits together with the bit just below them. From that group of three it chooses an addend of zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. It adds the addend to an accumulator and then shifts the accumulator and the multiplier register together two places to the right, keeping the sign. Because every step retires two multiplier bits, a product takes `WIDTH/2` steps.

A client places both operands on the inputs and pulses `start` while the block is idle. `busy` stays high during each step cycle. `done` then pulses for one cycle, and `product` holds the result until the next accepted start. The controller is a three-state machine. `IDLE` waits, and the transition `IDLE -> RUN` on `start` loads the operands and clears the accumulator. `RUN` performs one step per cycle. The transition `RUN -> RUN` is taken while steps remain, and `RUN -> FINISH` is taken on the last step. `FINISH` raises `done`, and `FINISH -> IDLE` is always taken on the next clock.

Top module: `booth4_mul`

## Requirements
- R1: While and right after reset (active-low `rst_n`), `busy` and `done` are 0 and `product` is 0.
- R2: Step i uses the three multiplier bits {q[2i+1], q[2i], q[2i-1]}, with q[-1] taken as 0. The group selects the addend as follows: 000 and 111 select zero; 001 and 010 select +M; 011 selects +2M; 100 selects -2M; 101 and 110 select -M.
- R3: At `done`, `product` equals the signed product of the two operands captured at the accepted start, for every operand pair including the most negative value on either or both inputs.
- R4: After the clock edge that accepts `start`, `busy` is high for exactly `WIDTH/2` cycles, and `done` is high in the cycle that follows the last of them.
- R5: `done` is high for exactly one cycle per multiplication.
- R6: Outside the step cycles, `product` holds its value until the next accepted `start`, whatever the operand inputs do.
- R7: `start` is ignored while `busy` or `done` is high. Operand inputs changed during a run do not affect its result.
- R8: Right shifts of the accumulator are arithmetic, so after every step the two top accumulator bits are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication, taken only when idle |
| multiplicand | input | WIDTH | Signed multiplicand M |
| multiplier | input | WIDTH | Signed multiplier Q |
| busy | output | 1 | High during each step cycle |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product: upper half from the accumulator, lower half from the multiplier register |

## Verification
The bench uses multipliers built so that each step sees a chosen bit triple, so every recoding entry decides a product bit by itself. It also uses all-ones and alternating patterns to tell apart long runs of ones from the worst case of constant transitions. It multiplies the most negative value by itself, by -1 and by the largest positive value, which exposes any shift that drops the sign or any ±2M addend that overflows. A set of random pairs covers mixed signs. Separate scenarios change the operands and pulse `start` during a run and during `done`, and they watch `product` through idle cycles.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RUN    = 2'd1,
        PH_FINISH = 2'd2
    } booth4_phase_t;

    // addend selection produced by the recoder
    typedef struct packed {
        logic act;   // a nonzero multiple is added
        logic dbl;   // the multiple is 2M rather than M
        logic neg;   // the multiple is subtracted
    } booth4_sel_t;

endpackage

// File: rtl/booth4_recode.sv
module booth4_recode
    import booth4_pkg::*;
(
    input  logic [2:0]  triple,
    output booth4_sel_t sel
);
    always_comb begin
        sel = '0;
        unique case (triple)
            3'b000, 3'b111: sel = '{act: 1'b0, dbl: 1'b0, neg: 1'b0};
            3'b001, 3'b010: sel = '{act: 1'b1, dbl: 1'b0, neg: 1'b0};
            3'b011:         sel = '{act: 1'b1, dbl: 1'b1, neg: 1'b0};
            3'b100:         sel = '{act: 1'b1, dbl: 1'b1, neg: 1'b1};
            3'b101, 3'b110: sel = '{act: 1'b1, dbl: 1'b0, neg: 1'b1};
            default:        sel = '0;
        endcase
    end
endmodule

// File: rtl/booth4_addend.sv
module booth4_addend
    import booth4_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int ACC_W = WIDTH + 2
) (
    input  logic [WIDTH-1:0] mcand,
    input  booth4_sel_t      sel,
    output logic [ACC_W-1:0] addend,
    output logic             carry
);
    logic [ACC_W-1:0] mcand_ext;
    logic [ACC_W-1:0] mag;

    // sign extension to accumulator width
    assign mcand_ext = {{2{mcand[WIDTH-1]}}, mcand};

    always_comb begin
        if (!sel.act)
            mag = '0;
        else if (sel.dbl)
            mag = {mcand_ext[ACC_W-2:0], 1'b0};
        else
            mag = mcand_ext;
    end

    // subtraction: one's complement here, +1 through the carry input
    assign addend = mag ^ {ACC_W{sel.neg}};
    assign carry  = sel.neg;
endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl
    import booth4_pkg::*;
#(
    parameter int STEPS = 4,
    localparam int CNT_W = $clog2(STEPS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    booth4_phase_t phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic last_step;

    assign last_step = (cnt_q == CNT_W'(STEPS - 1));

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_RUN;
                    cnt_d   = '0;
                end
            end
            PH_RUN: begin
                if (last_step) begin
                    phase_d = PH_FINISH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_FINISH: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (phase_q)
            PH_IDLE:   load = start;
            PH_RUN:    begin step = 1'b1; busy = 1'b1; end
            PH_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < CNT_W'(STEPS)));

    // R4
    done_follows_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!busy && !done));
endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
    import booth4_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int ACC_W = WIDTH + 2,
    localparam int STEPS = WIDTH / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     multiplicand,
    input  logic [WIDTH-1:0]     multiplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    logic             load, step;
    logic [ACC_W-1:0] acc_q;
    logic [WIDTH-1:0] mcand_q, mplier_q;
    logic             guard_q;
    logic [2:0]       triple;
    booth4_sel_t      sel;
    logic [ACC_W-1:0] addend, sum;
    logic             carry;

    booth4_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    assign triple = {mplier_q[1:0], guard_q};

    booth4_recode u_recode (
        .triple (triple),
        .sel    (sel)
    );

    booth4_addend #(.WIDTH(WIDTH)) u_addend (
        .mcand  (mcand_q),
        .sel    (sel),
        .addend (addend),
        .carry  (carry)
    );

    assign sum = acc_q + addend + {{(ACC_W-1){1'b0}}, carry};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            guard_q  <= 1'b0;
        end else if (load) begin
            acc_q    <= '0;
            mcand_q  <= multiplicand;
            mplier_q <= multiplier;
            guard_q  <= 1'b0;
        end else if (step) begin
            acc_q    <= {{2{sum[ACC_W-1]}}, sum[ACC_W-1:2]};
            mplier_q <= {sum[1:0], mplier_q[WIDTH-1:2]};
            guard_q  <= mplier_q[1];
        end
    end

    assign product = {acc_q[WIDTH-1:0], mplier_q};

    // R6
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(product));

    // R8
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step) |-> (acc_q[ACC_W-1] == acc_q[ACC_W-2]));

    // R2
    zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (triple == 3'b000 || triple == 3'b111)) |-> (addend == '0 && !carry));

    // R2
    neg_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && triple[2] && (triple[1:0] != 2'b11)) |-> carry);
endmodule

// File: tb/test_booth4_mul.sv
module test_booth4_mul;
    localparam int W = 8;
    localparam int STEPS = W / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] mcand = '0, mplier = '0;
    logic busy, done;
    logic [2*W-1:0] product;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    booth4_mul #(.WIDTH(W)) i_booth4_mul (
        .clk (clk), .rst_n (rst_n), .start (start),
        .multiplicand (mcand), .multiplier (mplier),
        .busy (busy), .done (done), .product (product)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] r;
        r = $signed(a) * $signed(b);
        return r;
    endfunction

    // launch one product, measure timing, return product at done
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string req, output logic [2*W-1:0] res);
        int cycles = 0;
        int busy_cnt = 0;
        @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && cycles < 60) begin
            if (busy) busy_cnt++;
            @(negedge clk);
            cycles++;
        end
        res = product;
        check(cycles == STEPS + 1, "R4 done latency", cycles, STEPS + 1);
        check(busy_cnt == STEPS, "R4 busy length", busy_cnt, STEPS);
        check(product == ref_prod(a, b), req, $signed(product), $signed(ref_prod(a, b)));
        @(negedge clk);
        check(!done, "R5 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset state", product, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && product == '0, "R1 after reset", product, 0);
    endtask

    // each multiplier places one triple in step 1 (bits 3:1), rest zero
    task automatic t_recode();
        logic [2*W-1:0] r;
        for (int t = 0; t < 8; t++) begin
            run_mul(8'sd37, 8'((t << 1)), "R2 recode triple step1", r);
            run_mul(-8'sd19, 8'((t << 1)), "R2 recode triple negM", r);
        end
        run_mul(8'sd5, 8'h01, "R2 implied zero below lsb", r);
    endtask

    task automatic t_corners();
        logic [2*W-1:0] r;
        run_mul(8'h80, 8'h80, "R3 min times min", r);
        run_mul(8'h80, 8'hFF, "R3 min times -1", r);
        run_mul(8'h80, 8'h7F, "R3 min times max", r);
        run_mul(8'h7F, 8'h80, "R3 max times min", r);
        run_mul(8'h7F, 8'h7F, "R3 max times max", r);
        run_mul(8'hFF, 8'hFF, "R3 all ones", r);
        run_mul(8'h55, 8'hAA, "R3 alternating", r);
        run_mul(8'h00, 8'h80, "R3 zero multiplicand", r);
        run_mul(8'hC3, 8'h00, "R8 negative M zero Q", r);
        run_mul(8'h81, 8'h6B, "R8 sign kept through shifts", r);
    endtask

    task automatic t_random();
        logic [2*W-1:0] r;
        void'($urandom(32'd7));
        for (int k = 0; k < 40; k++)
            run_mul(8'($urandom), 8'($urandom), "R3 random pair", r);
    endtask

    task automatic t_ignore_start();
        logic [2*W-1:0] exp = ref_prod(8'hE5, 8'h3C);
        int cycles = 0;
        @(negedge clk);
        mcand = 8'hE5; mplier = 8'h3C; start = 1'b1;
        @(negedge clk);
        mcand = 8'h11; mplier = 8'h22;   // start still high while busy
        @(negedge clk);
        start = 1'b0;
        cycles = 2;
        while (!done && cycles < 60) begin @(negedge clk); cycles++; end
        check(product == exp, "R7 start during run ignored", $signed(product), $signed(exp));
        start = 1'b1;                    // pulse during done
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R7 start during done ignored", busy, 0);
        @(negedge clk);
        check(product == exp, "R7 product after ignored start", $signed(product), $signed(exp));
    endtask

    task automatic t_hold();
        logic [2*W-1:0] r;
        logic [2*W-1:0] keep;
        run_mul(8'h9D, 8'h47, "R3 before hold", r);
        keep = r;
        for (int k = 0; k < 6; k++) begin
            mcand = 8'(k * 29); mplier = 8'(k * 83);
            @(negedge clk);
        end
        check(product == keep, "R6 product held while idle", product, keep);
    endtask

    initial begin
        t_reset();
        t_recode();
        t_corners();
        t_random();
        t_ignore_start();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule